// File: doc/BRIEF.md
# Erasable One-Time-Write Byte Array with Mode Decode

This block is a synthesizable, clock-driven model of an ultraviolet-erasable read-only byte memory. It decodes five operating modes from four control inputs: an active-low chip select, an active-low output gate, an active-low write strobe and a flag that stands in for the high programming supply. The bidirectional data pins are split into a data input, a data output and an output-drive enable. Analog levels and real-time delays are not modelled. Read access latency is a parameterised number of clock cycles.

A write can only clear bits. At the rising edge of the write strobe, the stored byte is ANDed with the incoming byte. The only way to return bits to one is a separate erase command. It walks the whole array and writes all ones, one location per cycle, and holds a busy flag for the whole sweep. Capacity is `2**ADDR_W` bytes. A full-size instance uses `ADDR_W = 14` (16,384 bytes). The default is kept smaller so that elaboration stays light.

The modes are decoded as follows:
- **Standby**: chip select high, supply flag low.
- **Read**: chip select low, supply flag low.
- **Write**: supply flag high, chip select low, strobe low.
- **Write-verify**: supply flag high, chip select low, strobe high.
- **Write-inhibit**: supply flag high, chip select high.

Top module: `uvrom_core`

## Requirements
- R1: The array holds `2**ADDR_W` bytes of 8 bits. Each address selects its own byte, independent of the others.
- R2: When `eraseReq` is high and no erase is running, `eraseBusy` goes high after the next clock edge. It stays high for exactly `2**ADDR_W` cycles. After that, every byte reads 8'hFF. A request made while busy has no effect on when the sweep ends.
- R3: With `hvPresent`=1 and `chipEnN`=0, a low-then-high pulse on `progStrobeN` stores (old byte AND `dataIn`) at `addr`. The write takes effect at the strobe's rising edge. No bit ever changes from 0 to 1 through this path.
- R4: With `chipEnN`=1, `dataOe` is 0 from the next clock edge on, whatever the level of `outEnN`.
- R5: In read mode (`hvPresent`=0, `chipEnN`=0) with `outEnN`=0, hold the inputs steady. `dataOe` stays low through the first `READ_LAT` clock edges that see the steady inputs. It is high after edge `READ_LAT+1`, and `dataOut` then equals the stored byte.
- R6: With `outEnN`=1, `dataOe` is 0. `dataOe` falls after the first clock edge that sees `outEnN` or `chipEnN` high.
- R7: In write mode (strobe low), `dataOe` is 0.
- R8: In write-verify mode with `outEnN`=0, the stored byte is driven after the same latency as a read.
- R9: In write-inhibit mode (`hvPresent`=1, `chipEnN`=1), a strobe pulse leaves the array unchanged.
- R10: A change of `addr` while reading restarts the latency count of R5.
- R11: While `eraseBusy` is high, `dataOe` is 0 and strobe pulses write nothing.
- R12: After reset, `dataOe`=0 and `eraseBusy`=0. `dataOut` is 8'h00 whenever `dataOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Byte applied during a write |
| dataOut | output | 8 | Byte driven out, zero when not driving |
| dataOe | output | 1 | Data pins driven when high |
| chipEnN | input | 1 | Active-low chip select |
| outEnN | input | 1 | Active-low output gate |
| progStrobeN | input | 1 | Active-low write strobe |
| hvPresent | input | 1 | High programming supply present |
| eraseReq | input | 1 | Start a whole-array erase |
| eraseBusy | output | 1 | Erase sweep in progress |

## Verification
The write-path assertion takes for granted that `addr` and `dataIn` stay steady from the strobe's falling edge through the cycle after its rising edge. It also assumes that every location has been erased before its first write, because the array itself has no reset value. The bench therefore opens with a full erase. It changes every input only on the falling clock edge and holds the address and data across each whole strobe pulse. The latency checks assume that inputs stay steady between samples, and each read task keeps them fixed until its check is done.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_READ,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_INHIBIT
  } romMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic progWrite;
    logic eraseWrite;
    logic driveOut;
  } romStrobe_t;

  function automatic romMode_e decodeMode(input logic chipEnN,
                                          input logic progStrobeN,
                                          input logic hvPresent);
    romMode_e m;
    if (!hvPresent)      m = chipEnN ? MODE_STANDBY : MODE_READ;
    else if (chipEnN)    m = MODE_INHIBIT;
    else if (progStrobeN) m = MODE_VERIFY;
    else                 m = MODE_PROGRAM;
    return m;
  endfunction

endpackage

// File: rtl/uvrom_ctrl.sv
module uvrom_ctrl
  import uvrom_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progStrobeN,
  input  logic              hvPresent,
  input  logic              eraseReq,
  output romStrobe_t        strobe,
  output logic [ADDR_W-1:0] eraseAddr,
  output logic              eraseBusy
);

  localparam int CNT_W = $clog2(READ_LAT + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(READ_LAT);

  romMode_e mode;
  logic busyQ;
  logic [ADDR_W-1:0] eAddrQ;
  logic progArmedQ;
  logic [ADDR_W-1:0] addrQ;
  logic wantQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic driveQ;
  logic want;
  logic settled;
  logic startErase;

  assign mode = decodeMode(chipEnN, progStrobeN, hvPresent);
  assign startErase = eraseReq && !busyQ;

  // Erase sweep sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      eAddrQ <= '0;
    end else if (startErase) begin
      busyQ  <= 1'b1;
      eAddrQ <= '0;
    end else if (busyQ) begin
      if (eAddrQ == LAST_ADDR) busyQ <= 1'b0;
      else                     eAddrQ <= eAddrQ + 1'b1;
    end
  end

  // Write strobe: armed while strobe low, fires at its rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) progArmedQ <= 1'b0;
    else       progArmedQ <= (mode == MODE_PROGRAM) && !busyQ;
  end

  // Read latency tracking
  assign want    = ((mode == MODE_READ) || (mode == MODE_VERIFY)) && !outEnN && !busyQ;
  assign settled = want && wantQ && (addr == addrQ);
  assign cntNext = !settled ? '0 : ((cntQ == LAT_C) ? cntQ : cntQ + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wantQ  <= 1'b0;
      cntQ   <= '0;
      driveQ <= 1'b0;
    end else begin
      addrQ  <= addr;
      wantQ  <= want;
      cntQ   <= cntNext;
      driveQ <= want && (cntNext == LAT_C);
    end
  end

  assign strobe.progWrite  = progArmedQ && (mode == MODE_VERIFY) && !busyQ;
  assign strobe.eraseWrite = busyQ;
  assign strobe.driveOut   = driveQ;
  assign eraseAddr = eAddrQ;
  assign eraseBusy = busyQ;

  // R4: deselect silences the pins
  a_r4_standby_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |=> !strobe.driveOut);

  // R7: write mode never drives
  a_r7_program_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PROGRAM) |=> !strobe.driveOut);

  // R11: erase sweep blocks the outputs
  a_r11_busy_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> !strobe.driveOut);

  // R2: sweep starts at location zero and ends after the last one
  a_r2_sweep_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> (eAddrQ == '0));
  a_r2_sweep_ends: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && (eAddrQ == LAST_ADDR)) |=> !busyQ);

  // R6: drive only begins after the gate was low
  a_r6_gate_before_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.driveOut) |-> $past(!outEnN && !chipEnN));

endmodule

// File: rtl/uvrom_datapath.sv
module uvrom_datapath
  import uvrom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  romStrobe_t        strobe,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] curByte;

  assign curByte = mem[addr];

  // Array: erase sets ones, write can only clear
  always_ff @(posedge clk) begin
    if (strobe.eraseWrite)     mem[eraseAddr] <= '1;
    else if (strobe.progWrite) mem[addr] <= curByte & dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else       rdQ <= curByte;
  end

  assign dataOut = strobe.driveOut ? rdQ : '0;

  // R3: a write never raises a bit
  a_r3_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progWrite |=> ((mem[$past(addr)] & ~$past(curByte)) == '0));

  // R12: pins quiet unless driving
  always_comb begin
    if (rstN && !strobe.driveOut)
      a_r12_quiet_zero: assert (dataOut == '0);
  end

endmodule

// File: rtl/uvrom_core.sv
module uvrom_core
  import uvrom_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              progStrobeN,
  input  logic              hvPresent,
  input  logic              eraseReq,
  output logic              eraseBusy
);

  romStrobe_t strobe;
  logic [ADDR_W-1:0] eraseAddr;

  uvrom_ctrl #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .chipEnN(chipEnN), .outEnN(outEnN),
    .progStrobeN(progStrobeN), .hvPresent(hvPresent), .eraseReq(eraseReq),
    .strobe(strobe), .eraseAddr(eraseAddr), .eraseBusy(eraseBusy)
  );

  uvrom_datapath #(.ADDR_W(ADDR_W), .DATA_W(8)) dp_i (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .eraseAddr(eraseAddr), .strobe(strobe), .dataOut(dataOut)
  );

  assign dataOe = strobe.driveOut;

endmodule

// File: tb/uvrom_core_tb_top.sv
module uvrom_core_tb_top;

  localparam int AW = 10;
  localparam int LAT = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe;
  logic chipEnN = 1'b1, outEnN = 1'b1, progStrobeN = 1'b1, hvPresent = 1'b0, eraseReq = 1'b0;
  logic eraseBusy;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uvrom_core #(.ADDR_W(AW), .READ_LAT(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .chipEnN(chipEnN), .outEnN(outEnN), .progStrobeN(progStrobeN),
    .hvPresent(hvPresent), .eraseReq(eraseReq), .eraseBusy(eraseBusy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    chipEnN = 1'b1; outEnN = 1'b1; progStrobeN = 1'b1; hvPresent = 1'b0;
    tick(1);
  endtask

  // Full sweep; checks exact busy length (R2)
  task automatic doErase(input bit pokeWhileBusy);
    eraseReq = 1'b1;
    tick(1);
    eraseReq = 1'b0;
    check("R2 busy rises", {7'd0, eraseBusy}, 8'd1);
    if (pokeWhileBusy) begin
      tick(5);
      eraseReq = 1'b1;
      tick(1);
      eraseReq = 1'b0;
      tick(DEPTH - 7);
    end else begin
      tick(DEPTH - 1);
    end
    check("R2 busy held full sweep", {7'd0, eraseBusy}, 8'd1);
    tick(1);
    check("R2 busy falls", {7'd0, eraseBusy}, 8'd0);
  endtask

  task automatic writeByte(input logic [AW-1:0] a, input logic [7:0] d, input logic ce);
    addr = a; dataIn = d; hvPresent = 1'b1; chipEnN = ce; outEnN = 1'b1; progStrobeN = 1'b1;
    tick(1);
    progStrobeN = 1'b0;
    tick(2);
    progStrobeN = 1'b1;
    tick(1);
    idle();
  endtask

  // Read mode access with latency check (R5)
  task automatic readByte(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    addr = a; hvPresent = 1'b0; chipEnN = 1'b0; outEnN = 1'b0; progStrobeN = 1'b1;
    tick(LAT);
    check({req, " R5 not yet driven"}, {7'd0, dataOe}, 8'd0);
    tick(1);
    check({req, " R5 driven"}, {7'd0, dataOe}, 8'd1);
    check(req, dataOut, exp);
  endtask

  task automatic tResetState();
    check("R12 reset oe", {7'd0, dataOe}, 8'd0);
    check("R12 reset busy", {7'd0, eraseBusy}, 8'd0);
    check("R12 reset data", dataOut, 8'h00);
  endtask

  task automatic tEraseAndWrite();
    doErase(1'b0);
    readByte(10'd5, 8'hFF, "R2 erased byte");
    idle();
    writeByte(10'd5, 8'hA5, 1'b0);
    writeByte(10'd1023, 8'h0F, 1'b0);
    writeByte(10'd0, 8'h3C, 1'b0);
    readByte(10'd5, 8'hA5, "R3 write 5");
    idle();
    readByte(10'd1023, 8'h0F, "R1 top address");
    idle();
    readByte(10'd0, 8'h3C, "R1 address zero");
    idle();
    readByte(10'd6, 8'hFF, "R1 neighbour untouched");
    idle();
    writeByte(10'd5, 8'h5F, 1'b0);
    readByte(10'd5, 8'h05, "R3 AND only clears");
    idle();
  endtask

  task automatic tGateAndStandby();
    readByte(10'd0, 8'h3C, "R5 read");
    outEnN = 1'b1;
    tick(1);
    check("R6 gate off drops oe", {7'd0, dataOe}, 8'd0);
    check("R12 data zero when off", dataOut, 8'h00);
    readByte(10'd0, 8'h3C, "R5 reread");
    chipEnN = 1'b1;
    tick(1);
    check("R4 standby drops oe", {7'd0, dataOe}, 8'd0);
    tick(LAT + 2);
    check("R4 standby stays off with gate low", {7'd0, dataOe}, 8'd0);
    readByte(10'd5, 8'h05, "R10 base");
    addr = 10'd1023;
    tick(1);
    check("R10 addr change drops oe", {7'd0, dataOe}, 8'd0);
    tick(LAT);
    check("R10 new byte after latency", dataOut, 8'h0F);
    idle();
  endtask

  task automatic tVerifyAndProgram();
    addr = 10'd20; dataIn = 8'h81; hvPresent = 1'b1; chipEnN = 1'b0; outEnN = 1'b0;
    progStrobeN = 1'b0;
    tick(LAT + 2);
    check("R7 write mode no drive", {7'd0, dataOe}, 8'd0);
    progStrobeN = 1'b1;
    tick(LAT);
    check("R8 verify latency", {7'd0, dataOe}, 8'd0);
    tick(1);
    check("R8 verify oe", {7'd0, dataOe}, 8'd1);
    check("R8 verify data", dataOut, 8'h81);
    idle();
  endtask

  task automatic tInhibit();
    writeByte(10'd7, 8'h00, 1'b1);
    readByte(10'd7, 8'hFF, "R9 inhibit keeps byte");
    idle();
  endtask

  task automatic tBusy();
    eraseReq = 1'b1;
    tick(1);
    eraseReq = 1'b0;
    addr = 10'd900; dataIn = 8'h00; hvPresent = 1'b1; chipEnN = 1'b0; outEnN = 1'b1;
    progStrobeN = 1'b0;
    tick(2);
    progStrobeN = 1'b1;
    tick(1);
    hvPresent = 1'b0; outEnN = 1'b0;
    tick(LAT + 2);
    check("R11 no drive while busy", {7'd0, dataOe}, 8'd0);
    idle();
    while (eraseBusy) tick(1);
    readByte(10'd900, 8'hFF, "R11 write ignored while busy");
    idle();
    readByte(10'd5, 8'hFF, "R2 second erase restores ones");
    idle();
    doErase(1'b1);
  endtask

  initial begin
    tick(3);
    tResetState();
    rstN = 1'b1;
    tick(2);
    tEraseAndWrite();
    tGateAndStandby();
    tVerifyAndProgram();
    tInhibit();
    tBusy();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule